// File: doc/BRIEF.md
# Walsh Spectrum Bit-Stream Analyzer

This block takes a serial stream of single-bit samples (the successive values one circuit input takes over a run of test vectors) and measures how strongly that stream correlates with each Walsh function. Each sample is first turned into a signed unit value: a 0 becomes -1 and a 1 becomes +1. The block then runs an in-place fast Walsh-Hadamard transform over a small coefficient store. The coefficients come out in natural Hadamard row order. Finally it labels each coefficient as essential or noise. A coefficient is essential when its normalized power, c_k^2 / N^2, is above the random-stream floor of 1/N. Only integer logic is used: the test is done as c_k^2 > N, so no division is needed.

A single-cycle `start` pulse begins a run. On each of the next N clock edges, one sample is taken from `bit_in`. The controller steps through four named states. IDLE goes to LOAD on `start`. LOAD goes to XFORM after the last sample. XFORM goes to CLASS after the last butterfly of the last pass. CLASS goes back to IDLE after the last coefficient is labelled and raises `done`. A `start` seen in any state abandons the current run and re-enters LOAD. Once a run completes, coefficients and flags can be read at any time through `rd_addr`. They stay readable until the next `start`.

Top module: `walsh_spectrum_analyzer`

## Requirements
- R1: Sample value 0 counts as -1 and sample value 1 counts as +1 (an all-zero stream gives coefficient 0 equal to -N).
- R2: Coefficient k equals the sum over n of x_n * (-1)^popcount(n AND k), where x_n is the signed sample n. Address k on `rd_addr` selects row k in natural Sylvester order.
- R3: Coefficients are two's-complement of LOG2N+2 bits and are exact over the full range -N..+N with no wrap, including every intermediate butterfly result.
- R4: `rd_essential` is 1 exactly when c_k * c_k > N (for N=128: |c_k| >= 12 is essential, |c_k| = 10 is noise).
- R5: After a `start` edge, the next N rising edges capture `bit_in` as samples 0..N-1 in order.
- R6: `done` is high for exactly one cycle. It rises after the edge that falls 2N + LOG2N*N/2 edges after the `start` edge (704 for N=128).
- R7: `valid` rises together with `done` and stays high until the next `start` or reset. While `valid` is low, `rd_coef` reads 0 and `rd_essential` reads 0.
- R8: A `start` in any state, including during loading, transforming, labelling or after completion, drops `valid` on the next edge and discards the earlier run. The new run's results depend only on the new samples.
- R9: During and straight after reset, `done` and `valid` are 0 and the read port returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins (or restarts) a run |
| bit_in | input | 1 | Serial sample, taken on the N edges after `start` |
| rd_addr | input | LOG2N | Coefficient index for readout |
| rd_coef | output | LOG2N+2 | Signed coefficient at `rd_addr` (0 when not valid) |
| rd_essential | output | 1 | Essential flag at `rd_addr` (0 when not valid) |
| done | output | 1 | One-cycle completion strobe |
| valid | output | 1 | Results held and readable |

## Verification
The bench uses a constant-one stream and a constant-zero stream. These tell apart a correct 0-to-minus-one mapping from an inverted or unsigned one, and they reach the positive and negative coefficient extremes. An alternating stream puts all of its energy into row 1, which exposes any swap between natural and sequency or bit-reversed order. Pseudo-random streams exercise every butterfly span at once. Two streams with 70 and 69 ones place coefficient 0 at 12 and at 10, on either side of the power threshold. Runs that are restarted mid-load and mid-transform show whether stale samples or partial passes leak into the new result.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_XFORM = 2'd2,
        ST_CLASS = 2'd3
    } wsa_state_e;

endpackage

// File: rtl/wsa_ctrl.sv
module wsa_ctrl
    import wsa_pkg::*;
#(
    parameter int N_SAMPLES = 128,
    parameter int LOG2N     = $clog2(N_SAMPLES),
    parameter int PW        = $clog2(LOG2N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output wsa_state_e       state,
    output logic [LOG2N-1:0] idx,
    output logic [PW-1:0]    pass,
    output logic             done,
    output logic             valid
);

    localparam logic [LOG2N-1:0] LAST_IDX  = LOG2N'(N_SAMPLES - 1);
    localparam logic [LOG2N-1:0] LAST_BFLY = LOG2N'(N_SAMPLES / 2 - 1);
    localparam logic [PW-1:0]    LAST_PASS = PW'(LOG2N - 1);

    wsa_state_e state_nx;
    logic       load_end;
    logic       bfly_end;
    logic       xform_end;
    logic       class_end;

    assign load_end  = (state == ST_LOAD)  && (idx == LAST_IDX);
    assign bfly_end  = (state == ST_XFORM) && (idx == LAST_BFLY);
    assign xform_end = bfly_end && (pass == LAST_PASS);
    assign class_end = (state == ST_CLASS) && (idx == LAST_IDX);

    // next-state decision
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_LOAD;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_LOAD:  state_nx = load_end  ? ST_XFORM : ST_LOAD;
                ST_XFORM: state_nx = xform_end ? ST_CLASS : ST_XFORM;
                ST_CLASS: state_nx = class_end ? ST_IDLE  : ST_CLASS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // sample / butterfly / label counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            pass <= '0;
        end else if (start) begin
            idx  <= '0;
            pass <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx  <= '0;
                    pass <= '0;
                end
                ST_LOAD: idx <= load_end ? '0 : idx + 1'b1;
                ST_XFORM: begin
                    if (bfly_end) begin
                        idx  <= '0;
                        pass <= xform_end ? '0 : pass + 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_CLASS: idx <= idx + 1'b1;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            valid <= 1'b0;
        end else begin
            done <= class_end && !start;
            if (start)          valid <= 1'b0;
            else if (class_end) valid <= 1'b1;
        end
    end

    // R5: the last sample edge hands over to the transform
    a_r5_load_to_xform: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && idx == LAST_IDX && !start) |=> (state == ST_XFORM));

    // R6: the strobe never lasts two cycles
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the strobe only follows the labelling phase
    a_r6_done_after_class: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_CLASS && state == ST_IDLE));

    // R8: restart throws away held results
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!valid && state == ST_LOAD));

endmodule

// File: rtl/wsa_butterfly.sv
module wsa_butterfly #(
    parameter int LOG2N = 7,
    parameter int PW    = $clog2(LOG2N),
    parameter int CW    = LOG2N + 2
) (
    input  logic [PW-1:0]        pass,
    input  logic [LOG2N-2:0]     bfly,
    input  logic signed [CW-1:0] top_in,
    input  logic signed [CW-1:0] bot_in,
    output logic [LOG2N-1:0]     addr_top,
    output logic [LOG2N-1:0]     addr_bot,
    output logic signed [CW-1:0] sum,
    output logic signed [CW-1:0] diff
);

    logic [LOG2N-1:0] ext;
    logic [LOG2N-1:0] span;
    logic [LOG2N-1:0] low_mask;

    assign ext      = {1'b0, bfly};
    assign span     = LOG2N'(1) << pass;
    assign low_mask = span - LOG2N'(1);

    // insert a zero at bit position 'pass' to form the upper partner
    assign addr_top = ((ext & ~low_mask) << 1) | (ext & low_mask);
    assign addr_bot = addr_top | span;

    assign sum  = top_in + bot_in;
    assign diff = top_in - bot_in;

endmodule

// File: rtl/wsa_classifier.sv
module wsa_classifier #(
    parameter int N_SAMPLES = 128,
    parameter int CW        = 9
) (
    input  logic signed [CW-1:0] coef,
    output logic                 essential
);

    localparam int SW = 2 * CW;

    logic signed [SW-1:0] coef_w;
    logic signed [SW-1:0] power;

    assign coef_w    = SW'(coef);
    assign power     = coef_w * coef_w;
    // c^2/N^2 > 1/N  <=>  c^2 > N
    assign essential = power > SW'(N_SAMPLES);

endmodule

// File: rtl/walsh_spectrum_analyzer.sv
module walsh_spectrum_analyzer
    import wsa_pkg::*;
#(
    parameter int N_SAMPLES = 128,
    parameter int LOG2N     = $clog2(N_SAMPLES),
    parameter int CW        = LOG2N + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 bit_in,
    input  logic [LOG2N-1:0]     rd_addr,
    output logic signed [CW-1:0] rd_coef,
    output logic                 rd_essential,
    output logic                 done,
    output logic                 valid
);

    localparam int PW = $clog2(LOG2N);
    localparam logic signed [CW-1:0] PLUS_ONE  = CW'(1);
    localparam logic signed [CW-1:0] MINUS_ONE = {CW{1'b1}};

    wsa_state_e           state;
    logic [LOG2N-1:0]     idx;
    logic [PW-1:0]        pass;
    logic [LOG2N-1:0]     addr_top;
    logic [LOG2N-1:0]     addr_bot;
    logic signed [CW-1:0] sum;
    logic signed [CW-1:0] diff;
    logic                 essential;

    logic signed [CW-1:0] coef_mem [N_SAMPLES];
    logic [N_SAMPLES-1:0] flag_mem;

    wsa_ctrl #(
        .N_SAMPLES(N_SAMPLES),
        .LOG2N    (LOG2N),
        .PW       (PW)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .state(state),
        .idx  (idx),
        .pass (pass),
        .done (done),
        .valid(valid)
    );

    wsa_butterfly #(
        .LOG2N(LOG2N),
        .PW   (PW),
        .CW   (CW)
    ) u_bfly (
        .pass    (pass),
        .bfly    (idx[LOG2N-2:0]),
        .top_in  (coef_mem[addr_top]),
        .bot_in  (coef_mem[addr_bot]),
        .addr_top(addr_top),
        .addr_bot(addr_bot),
        .sum     (sum),
        .diff    (diff)
    );

    wsa_classifier #(
        .N_SAMPLES(N_SAMPLES),
        .CW       (CW)
    ) u_class (
        .coef     (coef_mem[idx]),
        .essential(essential)
    );

    // coefficient store: sample load, then in-place butterflies
    always_ff @(posedge clk) begin
        if (!start) begin
            if (state == ST_LOAD) begin
                coef_mem[idx] <= bit_in ? PLUS_ONE : MINUS_ONE;
            end else if (state == ST_XFORM) begin
                coef_mem[addr_top] <= sum;
                coef_mem[addr_bot] <= diff;
            end
        end
    end

    // essential flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_mem <= '0;
        end else if (state == ST_CLASS && !start) begin
            flag_mem[idx] <= essential;
        end
    end

    assign rd_coef      = valid ? coef_mem[rd_addr] : '0;
    assign rd_essential = valid && flag_mem[rd_addr];

    // R3: butterfly outputs stay within the exact range
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFORM) |-> (sum <= N_SAMPLES && sum >= -N_SAMPLES &&
                                 diff <= N_SAMPLES && diff >= -N_SAMPLES));

endmodule

// File: tb/test_walsh_spectrum_analyzer.sv
`timescale 1ns/1ps
module test_walsh_spectrum_analyzer;

    localparam int N       = 128;
    localparam int LOG2N   = 7;
    localparam int CW      = 9;
    localparam int DONE_AT = 2 * N + LOG2N * N / 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 bit_in = 1'b0;
    logic [LOG2N-1:0]     rd_addr = '0;
    logic signed [CW-1:0] rd_coef;
    logic                 rd_essential;
    logic                 done;
    logic                 valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit checking = 1'b0;

    walsh_spectrum_analyzer #(.N_SAMPLES(N)) i_walsh_spectrum_analyzer (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_in(bit_in),
        .rd_addr(rd_addr), .rd_coef(rd_coef), .rd_essential(rd_essential),
        .done(done), .valid(valid)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural timing model (R6, R7, R8)
    int  cyc = 0;
    bit  run = 1'b0;
    bit  exp_done = 1'b0;
    bit  exp_valid = 1'b0;

    always @(posedge clk) begin
        exp_done = 1'b0;
        if (!rst_n) begin
            run = 1'b0; cyc = 0; exp_valid = 1'b0;
        end else if (start) begin
            run = 1'b1; cyc = 0; exp_valid = 1'b0;
        end else if (run) begin
            cyc++;
            if (cyc == DONE_AT) begin
                exp_done = 1'b1; exp_valid = 1'b1; run = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            check("R6 done strobe", int'(done), int'(exp_done));
            check("R7 valid level", int'(valid), int'(exp_valid));
        end
    end

    function automatic int ref_coef(input bit [N-1:0] s, input int k);
        int acc = 0;
        for (int n = 0; n < N; n++) begin
            int x = s[n] ? 1 : -1;
            if ($countones(n & k) % 2 == 1) acc -= x;
            else                            acc += x;
        end
        return acc;
    endfunction

    function automatic bit [N-1:0] prand(input int seed);
        bit [N-1:0] s;
        int unsigned x = seed;
        for (int n = 0; n < N; n++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            s[n] = x[7];
        end
        return s;
    endfunction

    task automatic feed(input bit [N-1:0] s, input int count);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < count; n++) begin
            bit_in = s[n];          // R5: captured at the next edge
            @(negedge clk);
        end
        bit_in = 1'b0;
    endtask

    task automatic readout(input bit [N-1:0] s, input string tag);
        while (!valid) @(negedge clk);
        for (int k = 0; k < N; k++) begin
            int c = ref_coef(s, k);
            rd_addr = LOG2N'(k);
            #0.5;
            check({tag, " R2 coef"}, int'(rd_coef), c);
            check({tag, " R4 flag"}, int'(rd_essential), int'(c * c > N));
            @(negedge clk);
        end
    endtask

    task automatic read0(input string tag, input int exp);
        rd_addr = '0;
        #0.5;
        check(tag, int'(rd_coef), exp);
    endtask

    initial begin
        bit [N-1:0] s;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 done in reset", int'(done), 0);
        check("R9 valid in reset", int'(valid), 0);
        check("R9 coef in reset", int'(rd_coef), 0);
        check("R9 flag in reset", int'(rd_essential), 0);
        rst_n = 1'b1;
        @(negedge clk);
        checking = 1'b1;
        check("R7 zero read before any run", int'(rd_coef), 0);

        // all ones: R3 top of range
        s = '1;
        feed(s, N); readout(s, "ones");
        read0("R3 coef0 at +N", N);

        // R8: restart after completion clears results
        s = '0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 valid dropped", int'(valid), 0);
        read0("R7 R8 read zero after restart", 0);
        for (int n = 0; n < N; n++) begin bit_in = 1'b0; @(negedge clk); end
        readout(s, "zeros");
        read0("R1 zeros give -N", -N);

        // alternating: energy only in row 1 (R2 natural order)
        for (int n = 0; n < N; n++) s[n] = n[0];
        feed(s, N); readout(s, "alt");
        rd_addr = 7'd1; #0.5;
        check("R2 alternating row1", int'(rd_coef), -N);

        // R4 boundary: 70 ones -> c0=12, 69 ones -> c0=10
        s = '0; for (int n = 0; n < 70; n++) s[n] = 1'b1;
        feed(s, N); readout(s, "b12");
        rd_addr = '0; #0.5;
        check("R4 c0=12 essential", int'(rd_essential), 1);
        s = '0; for (int n = 0; n < 69; n++) s[n] = 1'b1;
        feed(s, N); readout(s, "b10");
        rd_addr = '0; #0.5;
        check("R4 c0=10 noise", int'(rd_essential), 0);

        // pseudo-random streams
        s = prand(32'h1234_5677); feed(s, N); readout(s, "rnd1");
        s = prand(32'h0BAD_F00D); feed(s, N); readout(s, "rnd2");

        // R8: restart mid-load, then mid-transform
        feed(prand(32'h5555_1111), 40);
        s = prand(32'h7777_2222); feed(s, N); readout(s, "R8 midload");
        feed(prand(32'h3333_9999), N);
        repeat (200) @(negedge clk);
        s = prand(32'h2468_ACE1); feed(s, N); readout(s, "R8 midxform");

        repeat (4) @(negedge clk);
        checking = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule